// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

This block gathers peripheral interrupt lines into numbered groups of up to 32 sources each. The groups are numbered 8 to 26. Each group keeps a sticky status bit per source, an enable mask, and a read-only result equal to status AND enable. Every group drives one aggregated interrupt line. That line is the OR of the group's result bits, gated by the group's bit in a block-enable register.

Groups that are not restricted to aggregation also present their result bits as direct per-source lines. One global control bit gates all of those direct lines. Software reaches all state through a simple synchronous bus with word address, write data, write strobe and a combinational read port.

The enable mask and the block-enable register are never written whole. They change only through write-one-to-set and write-one-to-clear addresses, so that independent software agents can change single bits without a read-modify-write race.

Top module: `grp_irq_aggr`

## Requirements
- R1: After reset every status, enable and block-enable bit, the direct-enable control bit, every aggregated output and every direct output are 0.
- R2: A source input that is 1 at a clock edge sets its status bit at that edge. The bit stays set after the input returns to 0.
- R3: A write to a group's status word (word address 4*(g-8)+0 for group g) clears each status bit written as 1. Bits written as 0 keep their value.
- R4: If a source input is 1 in the same cycle as a write that clears its status bit, the bit stays set.
- R5: Writing 1s to a group's enable-set word (offset 1) sets those enable bits. Writing 1s to its enable-clear word (offset 2) clears them. Zero bits change nothing, and reading either word returns the current enable mask.
- R6: A group's result word (offset 3) reads as status AND enable. Writes to it change no state.
- R7: The aggregated output for group g (irq_o bit g-8) is 1 exactly when the group has at least one result bit set and bit g of the block-enable register is 1.
- R8: Writing 1s to word 128 sets block-enable bits, and writing 1s to word 129 clears them. Both words read back the register. Only bits 8 to 26 are implemented; the others read 0.
- R9: Group-region addresses whose slot is 19 or more, word 131, and every other unmapped address read 0, and writes to them change no state.
- R10: Groups 8 to 12 and 24 to 26 are aggregated only. Their direct outputs are always 0.
- R11: For the other groups, a direct output equals that source's result bit while bit 0 of control word 130 is 1. The direct output is 0 while that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Word address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per asserted cycle |
| rdata_o | output | 32 | Combinational read data for addr_i |
| src_i | input | 608 | Source inputs, group g at bits [(g-8)*32 +: 32] |
| irq_o | output | 19 | Aggregated output per group, bit g-8 for group g |
| dir_o | output | 608 | Direct per-source outputs, same layout as src_i |

## Verification
Sparse random source pulses run together with random writes that spread over status, enable-set, enable-clear, result, global and unmapped addresses. Comparing every output and one random read each cycle against a bench model shows whether latching, masking and gating interact correctly. Directed cases cover what random traffic seldom hits. A clear that collides with a new pulse separates set-priority from clear-priority. Writes to the result word and to slots beyond group 26 reveal any aliasing into live slots. One source is enabled in an aggregation-only group and another in a direct-capable group, so a wrong capability mask shows on dir_o. The block-enable is toggled while a result is pending, which shows whether the gate uses the right bit position.

// File: rtl/gia_pkg.sv
package gia_pkg;

   localparam int unsigned WORD_W = 32;

   // word offset inside one group slot
   typedef enum logic [1:0] {
      OFS_STAT  = 2'd0,
      OFS_ENSET = 2'd1,
      OFS_ENCLR = 2'd2,
      OFS_RES   = 2'd3
   } grp_ofs_e;

   // word offset inside the global window
   typedef enum logic [1:0] {
      GLB_BLKSET = 2'd0,
      GLB_BLKCLR = 2'd1,
      GLB_CTRL   = 2'd2,
      GLB_NONE   = 2'd3
   } glb_ofs_e;

   typedef struct packed {
      logic     grp_hit;
      grp_ofs_e grp_ofs;
      logic     glb_hit;
      glb_ofs_e glb_ofs;
   } acc_dec_t;

   // ones on bit positions lo..hi
   function automatic logic [WORD_W-1:0] span_mask(input int lo, input int hi);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(WORD_W); i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/gia_addr_dec.sv
module gia_addr_dec
   import gia_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_GRP = 19,
   localparam int SLOT_W = ADDR_W - 3
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output acc_dec_t           dec_o,
   output logic [NUM_GRP-1:0] grp_sel_o
);

   logic [SLOT_W-1:0] slot;
   logic              grp_win;
   logic              grp_hit;

   assign slot    = addr_i[ADDR_W-2:2];
   assign grp_win = ~addr_i[ADDR_W-1];

   always_comb begin
      grp_hit = 1'b0;
      for (int k = 0; k < NUM_GRP; k++) begin
         if (slot == SLOT_W'(k)) grp_hit = grp_win;
      end
   end

   generate
      for (genvar k = 0; k < NUM_GRP; k++) begin : g_sel
         assign grp_sel_o[k] = grp_win && (slot == SLOT_W'(k));
      end
   endgenerate

   always_comb begin
      dec_o         = '0;
      dec_o.glb_ofs = GLB_NONE;
      dec_o.grp_hit = grp_hit;
      dec_o.grp_ofs = grp_ofs_e'(addr_i[1:0]);
      if (addr_i[ADDR_W-1] && (slot == '0) && (addr_i[1:0] != 2'd3)) begin
         dec_o.glb_hit = 1'b1;
         dec_o.glb_ofs = glb_ofs_e'(addr_i[1:0]);
      end
   end

endmodule

// File: rtl/gia_group.sv
module gia_group #(
   parameter int   SRC_W     = 32,
   parameter logic DIRECT_OK = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SRC_W-1:0] src_i,
   input  logic [SRC_W-1:0] wdata_i,
   input  logic             stat_clr_i,
   input  logic             en_set_i,
   input  logic             en_clr_i,
   input  logic             dir_en_i,
   input  logic             blk_en_i,
   output logic [SRC_W-1:0] stat_o,
   output logic [SRC_W-1:0] en_o,
   output logic [SRC_W-1:0] res_o,
   output logic             irq_o,
   output logic [SRC_W-1:0] dir_o
);

   logic [SRC_W-1:0] stat_q, en_q, clr_mask;

   assign clr_mask = stat_clr_i ? wdata_i : '0;

   // a new pulse outranks a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q <= '0;
      else         stat_q <= (stat_q & ~clr_mask) | src_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q <= '0;
      else if (en_set_i) en_q <= en_q | wdata_i;
      else if (en_clr_i) en_q <= en_q & ~wdata_i;
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign res_o  = stat_q & en_q;
   assign irq_o  = blk_en_i & (|res_o);

   generate
      if (DIRECT_OK) begin : g_direct
         assign dir_o = res_o & {SRC_W{dir_en_i}};
      end else begin : g_aggr_only
         assign dir_o = '0;
      end
   endgenerate

endmodule

// File: rtl/gia_blk_ctrl.sv
module gia_blk_ctrl
   import gia_pkg::*;
#(
   parameter int FIRST_GRP = 8,
   parameter int LAST_GRP  = 26
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              blk_set_i,
   input  logic              blk_clr_i,
   input  logic              ctrl_we_i,
   output logic [WORD_W-1:0] blk_en_o,
   output logic              dir_en_o
);

   localparam logic [WORD_W-1:0] IMPL_MASK = span_mask(FIRST_GRP, LAST_GRP);

   logic [WORD_W-1:0] blk_q;
   logic              dir_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        blk_q <= '0;
      else if (blk_set_i) blk_q <= (blk_q | wdata_i) & IMPL_MASK;
      else if (blk_clr_i) blk_q <= blk_q & ~wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dir_q <= 1'b0;
      else if (ctrl_we_i) dir_q <= wdata_i[0];
   end

   assign blk_en_o = blk_q;
   assign dir_en_o = dir_q;

endmodule

// File: rtl/grp_irq_aggr.sv
module grp_irq_aggr
   import gia_pkg::*;
#(
   parameter int                FIRST_GRP = 8,
   parameter int                LAST_GRP  = 26,
   parameter int                SRC_W     = 32,
   parameter int                ADDR_W    = 8,
   parameter logic [WORD_W-1:0] AGGR_ONLY = 32'h0700_1F00,
   localparam int               NUM_GRP   = LAST_GRP - FIRST_GRP + 1,
   localparam int               FLAT_W    = NUM_GRP * SRC_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              we_i,
   output logic [WORD_W-1:0] rdata_o,
   input  logic [FLAT_W-1:0] src_i,
   output logic [NUM_GRP-1:0] irq_o,
   output logic [FLAT_W-1:0] dir_o
);

   generate
      if (SRC_W > int'(WORD_W) || SRC_W < 1) begin : g_bad_srcw
         $error("SRC_W must lie in 1..WORD_W");
      end
      if (FIRST_GRP > LAST_GRP || LAST_GRP >= int'(WORD_W)) begin : g_bad_range
         $error("group range must be ordered and fit the block-enable word");
      end
      if (NUM_GRP * 4 > (1 << (ADDR_W - 1))) begin : g_bad_addr
         $error("ADDR_W too small for the group slots");
      end
   endgenerate

   acc_dec_t          dec;
   logic [NUM_GRP-1:0] grp_sel;
   logic [WORD_W-1:0] blk_en_q;
   logic              dir_en_q;

   logic [SRC_W-1:0]  stat_a [NUM_GRP];
   logic [SRC_W-1:0]  en_a   [NUM_GRP];
   logic [SRC_W-1:0]  res_a  [NUM_GRP];
   logic [FLAT_W-1:0] stat_flat, en_flat;

   gia_addr_dec #(
      .ADDR_W (ADDR_W),
      .NUM_GRP(NUM_GRP)
   ) u_dec (
      .addr_i   (addr_i),
      .dec_o    (dec),
      .grp_sel_o(grp_sel)
   );

   gia_blk_ctrl #(
      .FIRST_GRP(FIRST_GRP),
      .LAST_GRP (LAST_GRP)
   ) u_blk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wdata_i  (wdata_i),
      .blk_set_i(we_i && dec.glb_hit && dec.glb_ofs == GLB_BLKSET),
      .blk_clr_i(we_i && dec.glb_hit && dec.glb_ofs == GLB_BLKCLR),
      .ctrl_we_i(we_i && dec.glb_hit && dec.glb_ofs == GLB_CTRL),
      .blk_en_o (blk_en_q),
      .dir_en_o (dir_en_q)
   );

   generate
      for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
         logic wr_k;
         assign wr_k = we_i && grp_sel[k];

         gia_group #(
            .SRC_W    (SRC_W),
            .DIRECT_OK(!AGGR_ONLY[FIRST_GRP+k])
         ) u_grp (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .src_i     (src_i[k*SRC_W +: SRC_W]),
            .wdata_i   (wdata_i[SRC_W-1:0]),
            .stat_clr_i(wr_k && dec.grp_ofs == OFS_STAT),
            .en_set_i  (wr_k && dec.grp_ofs == OFS_ENSET),
            .en_clr_i  (wr_k && dec.grp_ofs == OFS_ENCLR),
            .dir_en_i  (dir_en_q),
            .blk_en_i  (blk_en_q[FIRST_GRP+k]),
            .stat_o    (stat_a[k]),
            .en_o      (en_a[k]),
            .res_o     (res_a[k]),
            .irq_o     (irq_o[k]),
            .dir_o     (dir_o[k*SRC_W +: SRC_W])
         );

         assign stat_flat[k*SRC_W +: SRC_W] = stat_a[k];
         assign en_flat[k*SRC_W +: SRC_W]   = en_a[k];
      end
   endgenerate

   logic [SRC_W-1:0] rd_grp;

   always_comb begin
      rd_grp = '0;
      for (int k = 0; k < NUM_GRP; k++) begin
         if (grp_sel[k]) begin
            case (dec.grp_ofs)
               OFS_STAT:            rd_grp = stat_a[k];
               OFS_ENSET, OFS_ENCLR: rd_grp = en_a[k];
               default:             rd_grp = res_a[k];
            endcase
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (dec.grp_hit) begin
         rdata_o[SRC_W-1:0] = rd_grp;
      end else if (dec.glb_hit) begin
         case (dec.glb_ofs)
            GLB_BLKSET, GLB_BLKCLR: rdata_o = blk_en_q;
            GLB_CTRL:               rdata_o[0] = dir_en_q;
            default:                rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/grp_irq_aggr_chk.sv
module grp_irq_aggr_chk
   import gia_pkg::*;
#(
   parameter int                FIRST_GRP = 8,
   parameter int                NUM_GRP   = 19,
   parameter int                SRC_W     = 32,
   parameter logic [WORD_W-1:0] AGGR_ONLY = 32'h0700_1F00,
   localparam int               FLAT_W    = NUM_GRP * SRC_W
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [FLAT_W-1:0]  src_i,
   input logic [NUM_GRP-1:0] irq_o,
   input logic [FLAT_W-1:0]  dir_o,
   input logic [FLAT_W-1:0]  stat_flat,
   input logic [FLAT_W-1:0]  en_flat,
   input logic [WORD_W-1:0]  blk_en_q,
   input logic               dir_en_q
);

   logic [FLAT_W-1:0] aggr_flat;
   generate
      for (genvar k = 0; k < NUM_GRP; k++) begin : g_m
         assign aggr_flat[k*SRC_W +: SRC_W] = {SRC_W{AGGR_ONLY[FIRST_GRP+k]}};
      end
   endgenerate

   // R2
   latch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> ((stat_flat & $past(src_i)) == $past(src_i)));

   // R6
   dir_within_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_o & ~(stat_flat & en_flat)) == '0);

   // R7
   irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o & ~blk_en_q[FIRST_GRP +: NUM_GRP]) == '0);

   // R10
   aggr_only_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_o & aggr_flat) == '0);

   // R11
   dir_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dir_en_q |-> (dir_o == '0));

endmodule

bind grp_irq_aggr grp_irq_aggr_chk #(
   .FIRST_GRP(FIRST_GRP),
   .NUM_GRP  (NUM_GRP),
   .SRC_W    (SRC_W),
   .AGGR_ONLY(AGGR_ONLY)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .src_i    (src_i),
   .irq_o    (irq_o),
   .dir_o    (dir_o),
   .stat_flat(stat_flat),
   .en_flat  (en_flat),
   .blk_en_q (blk_en_q),
   .dir_en_q (dir_en_q)
);

// File: tb/grp_irq_aggr_tb.sv
module grp_irq_aggr_tb;

   localparam int CLK_PERIOD = 10;
   localparam int FG = 8;
   localparam int LG = 26;
   localparam int NG = LG - FG + 1;
   localparam int SW = 32;
   localparam int FW = NG * SW;
   localparam logic [31:0] AGGR  = 32'h0700_1F00;
   localparam logic [31:0] VMASK = 32'h07FF_FF00;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [7:0]    addr_i = '0;
   logic [31:0]   wdata_i = '0;
   logic          we_i = 1'b0;
   logic [31:0]   rdata_o;
   logic [FW-1:0] src_i = '0;
   logic [NG-1:0] irq_o;
   logic [FW-1:0] dir_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] m_stat [NG];
   logic [31:0] m_en   [NG];
   logic [31:0] m_blk;
   logic        m_dir;

   always #(CLK_PERIOD/2) clk = ~clk;

   grp_irq_aggr u_dut (
      .clk_i  (clk),
      .rst_ni (rst_ni),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .we_i   (we_i),
      .rdata_o(rdata_o),
      .src_i  (src_i),
      .irq_o  (irq_o),
      .dir_o  (dir_o)
   );

   task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      int s;
      s = int'(a[6:2]);
      if (!a[7]) begin
         if (s >= NG) return 32'h0;
         case (a[1:0])
            2'd0:    return m_stat[s];
            2'd1:    return m_en[s];
            2'd2:    return m_en[s];
            default: return m_stat[s] & m_en[s];
         endcase
      end
      if (a == 8'd128 || a == 8'd129) return m_blk;
      if (a == 8'd130) return {31'b0, m_dir};
      return 32'h0;
   endfunction

   function automatic logic [FW-1:0] exp_irq();
      logic [FW-1:0] v;
      v = '0;
      for (int k = 0; k < NG; k++) v[k] = m_blk[FG+k] && ((m_stat[k] & m_en[k]) != 0);
      return v;
   endfunction

   function automatic logic [FW-1:0] exp_dir();
      logic [FW-1:0] v;
      v = '0;
      for (int k = 0; k < NG; k++)
         if (!AGGR[FG+k] && m_dir) v[k*SW +: SW] = m_stat[k] & m_en[k];
      return v;
   endfunction

   task automatic model_upd(input logic w, input logic [7:0] a, input logic [31:0] d,
                            input logic [FW-1:0] s);
      for (int k = 0; k < NG; k++) begin
         logic hit;
         hit = w && !a[7] && (int'(a[6:2]) == k);
         m_stat[k] = (m_stat[k] & ~((hit && a[1:0] == 2'd0) ? d : 32'h0)) | s[k*SW +: SW];
         if (hit && a[1:0] == 2'd1) m_en[k] = m_en[k] | d;
         if (hit && a[1:0] == 2'd2) m_en[k] = m_en[k] & ~d;
      end
      if (w && a == 8'd128) m_blk = (m_blk | d) & VMASK;
      if (w && a == 8'd129) m_blk = m_blk & ~d;
      if (w && a == 8'd130) m_dir = d[0];
   endtask

   task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [FW-1:0] s);
      we_i = w; addr_i = a; wdata_i = d; src_i = s;
      @(posedge clk);
      model_upd(w, a, d, s);
      #1;
      we_i = 1'b0; src_i = '0;
      #1;
   endtask

   task automatic rd(input string req, input logic [7:0] a);
      addr_i = a;
      #1;
      chk(req, FW'(rdata_o), FW'(exp_rd(a)));
   endtask

   task automatic outs(input string req);
      chk({req, " irq"}, FW'(irq_o), exp_irq());
      chk({req, " dir"}, dir_o, exp_dir());
   endtask

   function automatic logic [FW-1:0] one_src(input int slot, input int bitn);
      logic [FW-1:0] v;
      v = '0;
      v[slot*SW + bitn] = 1'b1;
      return v;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int k = 0; k < NG; k++) begin m_stat[k] = '0; m_en[k] = '0; end
      m_blk = '0; m_dir = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_ni = 1'b1;
      #1;

      // R1: everything clear after reset
      chk("R1 irq", FW'(irq_o), '0);
      chk("R1 dir", dir_o, '0);
      rd("R1 stat", 8'd0);
      rd("R1 en", 8'd5);
      rd("R1 blk", 8'd128);
      rd("R1 ctrl", 8'd130);

      // R2: latch and hold
      step(1'b0, 8'd0, 32'h0, one_src(2, 5));
      rd("R2 latch", 8'd8);
      step(1'b0, 8'd0, 32'h0, '0);
      rd("R2 hold", 8'd8);
      chk("R2 value", FW'(rdata_o), FW'(32'h20));

      // R3: W1C, zero has no effect
      step(1'b1, 8'd8, 32'h0, '0);
      rd("R3 zero write", 8'd8);
      step(1'b1, 8'd8, 32'h20, '0);
      rd("R3 clear", 8'd8);
      chk("R3 cleared", FW'(rdata_o), '0);

      // R4: pulse wins over clear in the same cycle
      step(1'b0, 8'd0, 32'h0, one_src(3, 7));
      step(1'b1, 8'd12, 32'h80, one_src(3, 7));
      rd("R4 set wins", 8'd12);
      chk("R4 value", FW'(rdata_o), FW'(32'h80));

      // R5: enable set/clear
      step(1'b1, 8'd13, 32'h0000_00F0, '0);
      rd("R5 set rd", 8'd13);
      rd("R5 clr rd", 8'd14);
      step(1'b1, 8'd14, 32'h0000_0030, '0);
      rd("R5 after clr", 8'd13);
      step(1'b1, 8'd13, 32'h0, '0);
      rd("R5 zero set", 8'd14);
      chk("R5 value", FW'(rdata_o), FW'(32'hC0));

      // R6: result read, writes ignored
      rd("R6 result", 8'd15);
      chk("R6 value", FW'(rdata_o), FW'(32'h80));
      step(1'b1, 8'd15, 32'hFFFF_FFFF, '0);
      rd("R6 res after wr", 8'd15);
      rd("R6 stat after wr", 8'd12);

      // R7: gated by group bit (group 11 -> block-enable bit 11)
      outs("R7 gated off");
      step(1'b1, 8'd128, 32'h0000_0800, '0);
      outs("R7 gate on");
      chk("R7 irq3", FW'(irq_o[3]), FW'(1'b1));
      step(1'b1, 8'd129, 32'h0000_0800, '0);
      outs("R7 gate off again");

      // R8: block-enable implemented bits
      step(1'b1, 8'd128, 32'hFFFF_FFFF, '0);
      rd("R8 mask", 8'd128);
      chk("R8 value", FW'(rdata_o), FW'(VMASK));
      step(1'b1, 8'd129, 32'h0000_FF00, '0);
      rd("R8 clr", 8'd129);

      // R9: unmapped addresses
      step(1'b1, 8'd81, 32'hFFFF_FFFF, '0);
      step(1'b1, 8'd80, 32'hFFFF_FFFF, '0);
      rd("R9 slot20 rd", 8'd81);
      rd("R9 word131", 8'd131);
      rd("R9 word200", 8'd200);
      for (int k = 0; k < NG; k++) rd("R9 no alias en", 8'(k*4 + 1));
      for (int k = 0; k < NG; k++) rd("R9 no alias stat", 8'(k*4));

      // R10 / R11: direct outputs
      step(1'b1, 8'd1, 32'h0000_0001, '0);
      step(1'b1, 8'd21, 32'h0000_0002, '0);
      step(1'b0, 8'd0, 32'h0, one_src(0, 0) | one_src(5, 1));
      outs("R11 dir off");
      chk("R11 dir zero", dir_o, '0);
      step(1'b1, 8'd130, 32'h1, '0);
      rd("R11 ctrl", 8'd130);
      outs("R11 dir on");
      chk("R11 grp13 bit", FW'(dir_o[5*SW + 1]), FW'(1'b1));
      chk("R10 grp8 quiet", FW'(dir_o[0 +: SW]), '0);
      outs("R10 irq grp8");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [7:0]    a;
         logic [31:0]   d;
         logic [FW-1:0] s;
         int            r;
         r = int'($urandom % 10);
         if (r < 7) a = 8'($urandom % 128);
         else       a = 8'(128 + ($urandom % 4));
         d = $urandom;
         if ((a[1:0] == 2'd0 && !a[7]) && ($urandom % 2 == 0)) d = 32'hFFFF_FFFF;
         for (int k = 0; k < NG; k++)
            s[k*SW +: SW] = $urandom & $urandom & $urandom & $urandom;
         step(($urandom % 4) != 0, a, d, s);
         outs("R7/R11 random");
         rd("R5/R6/R8 random rd", 8'($urandom % 256));
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule